// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block is one general-purpose I/O port of up to 32 pins together with the logic that turns pin activity into an interrupt. Software reaches every register through a simple single-cycle read/write bus. For each pin it chooses whether the pad is driven, whether its input is sampled, which value is driven out, and which condition on the pin raises an interrupt.

Pin inputs are brought into the clock domain by a two-flop synchronizer. A third flop holds the previous sample, so edges are found by comparing two consecutive synchronized values. Each pin has a 2-bit trigger code that selects a high level, a low level, a rising edge or a falling edge. A matching condition sets the pin's pending bit, which software clears by writing one. A mask register chooses which pending pins may reach the shared interrupt line. A port control field holds the port enable, a sticky port-pending flag and a sample-clock select bit. The field sits at a 5-bit stride chosen by a port index. Interrupts on both edges are not handled in hardware: software flips the trigger code after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe`, `pin_ie` and `pin_out` are zero and `irq` is low.
- R2: `pin_oe` and `pin_ie` follow the output-enable (0x00) and input-enable (0x04) registers. A write to the data register (0x08) changes only those `pin_out` bits whose output enable is set.
- R3: A read of the data register returns the synchronized pin inputs ANDed with the input-enable bits. A change on a pin is visible there within three clocks.
- R4: Trigger codes are 2'b00 high level, 2'b01 low level, 2'b10 rising edge and 2'b11 falling edge. An edge code sets the pending bit once per matching edge, and the opposite edge sets nothing.
- R5: The trigger code of pin p sits at bits 2*(p mod 16)+1:2*(p mod 16). Pins 0-15 use the word at 0x10 and pins 16-31 use the word at 0x0C.
- R6: A level code sets the pending bit on every sample while the level holds, so a clear written during the level leaves the bit set. Once the level is gone, a clear removes it.
- R7: Writing 1 to a bit of the pending register (0x18) clears that bit. Writing 0 leaves it unchanged.
- R8: If a clear and a new event hit the same pin in the same cycle, the pending bit stays set.
- R9: `irq` is high exactly when the port enable is set and at least one pin is both pending and unmasked (mask register 0x14, 1 = allowed). Masking does not stop a pin from becoming pending.
- R10: The port control word (0x1C) holds a field at bit 5*PORT_IDX. Field bit +0 is the enable, +1 is the port-pending flag and +2 is the sample-clock select. The port-pending flag is set on every cycle that an unmasked pin is pending, and writing 1 clears it once that condition is gone. The select bit reads back and has no other effect. All other bits of the word read zero.
- R11: Addresses outside the eight registers read zero, and writes to them change nothing.
- R12: The enable, trigger and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the read strobe |
| pin_in | input | NUM_PINS | Asynchronous pad inputs |
| pin_out | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_ie | output | NUM_PINS | Pad input enables |
| irq | output | 1 | Combined port interrupt |

## Verification
On every cycle the assertions check four things. A detected event always leaves its pending bit set on the next cycle. A clear without a competing event always drops the bit. No pending bit appears without an event. `pin_out` never moves on a pin whose output was disabled. They also check that an unmasked pending pin always sets the port-pending flag. Only the bench scenarios can show the meaning of each trigger code, the split layout of the trigger words, the three-clock input latency, the re-arming of levels against software clears, and the interrupt gating by mask and enable. A timed scenario shows that an edge arriving in the same cycle as a clear wins.

// File: rtl/gib_pkg.sv
// Package: shared constants and types of the GPIO bank interrupt controller.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package gib_pkg;

    // Trigger codes held in the 2-bit per-pin fields
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    localparam int unsigned REG_W = 32;

    // Register byte offsets
    localparam int unsigned OFS_OUTEN   = 'h00;
    localparam int unsigned OFS_INEN    = 'h04;
    localparam int unsigned OFS_DATA    = 'h08;
    localparam int unsigned OFS_TYPE_UP = 'h0C;  // pins 16..31
    localparam int unsigned OFS_TYPE_LO = 'h10;  // pins 0..15
    localparam int unsigned OFS_MASK    = 'h14;
    localparam int unsigned OFS_PEND    = 'h18;
    localparam int unsigned OFS_CTRL    = 'h1C;

    // Port control field layout
    localparam int unsigned CTL_STRIDE = 5;
    localparam int unsigned CTL_EN     = 0;
    localparam int unsigned CTL_PEND   = 1;
    localparam int unsigned CTL_SCLK   = 2;

    localparam int unsigned PINS_PER_TYPE_WORD = 16;

endpackage

// File: rtl/gib_pin_sync.sv
// Module: two-flop input synchronizer followed by a history flop.
// cur is the synchronized pin value, prev is the value one sample earlier.
// Assumes pin_in may change at any time relative to clk.
module gib_pin_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] cur,
    output logic [NPINS-1:0] prev
);

    logic [NPINS-1:0] meta_q;

    // Synchronizer chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur    <= '0;
            prev   <= '0;
        end else begin
            meta_q <= pin_in;
            cur    <= meta_q;
            prev   <= cur;
        end
    end

endmodule

// File: rtl/gib_event_detect.sv
// Module: per-pin trigger decode. Produces a one-cycle event for edge codes
// and a continuous event for level codes. Purely combinational.
// Assumes the type words use the split layout: pins 0..15 in type_lo,
// pins 16..31 in type_up, two bits per pin at 2*(pin mod 16).
module gib_event_detect
    import gib_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] cur,
    input  logic [NPINS-1:0] prev,
    input  logic [REG_W-1:0] type_lo,
    input  logic [REG_W-1:0] type_up,
    output logic [NPINS-1:0] ev
);

    localparam int PPW = int'(PINS_PER_TYPE_WORD);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int SLOT = p % PPW;
        trig_e code;

        // Select this pin's code from the word that holds it
        if (p < PPW) begin : g_lo
            always_comb code = trig_e'(type_lo[2*SLOT +: 2]);
        end else begin : g_up
            always_comb code = trig_e'(type_up[2*SLOT +: 2]);
        end

        // Decode the condition named by the code
        always_comb begin
            unique case (code)
                TRIG_HIGH: ev[p] = cur[p];
                TRIG_LOW:  ev[p] = ~cur[p];
                TRIG_RISE: ev[p] = cur[p] & ~prev[p];
                TRIG_FALL: ev[p] = ~cur[p] & prev[p];
                default:   ev[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gib_pend_reg.sv
// Module: per-pin pending latches with write-one-to-clear.
// An event in the same cycle as a clear wins. Assumes clr is a one-cycle
// strobe vector taken from a bus write.
module gib_pend_reg #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] ev,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] pend
);

    // Capture events, drop bits that software clears
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | ev;
    end

    // R8: an event always leaves its bit set, whatever the clear did
    assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((pend & $past(ev)) == $past(ev)));

    // R7: a clear with no competing event removes the bit
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~ev) != '0) |=> ((pend & $past(clr & ~ev)) == '0));

    // R4: no pending bit rises without an event
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(ev)) == '0));

endmodule

// File: rtl/gpio_irq_bank.sv
// Module: top of the GPIO bank interrupt controller. Holds the bus-visible
// registers, drives the pad controls and forms the combined interrupt.
// Assumes a single-cycle bus: one access per cycle with bus_en high, and
// read data returned on bus_rdata one clock after the read strobe.
module gpio_irq_bank
    import gib_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int PORT_IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_ie,
    output logic                irq
);

    localparam int FBASE = PORT_IDX * int'(CTL_STRIDE);
    localparam int F_EN  = FBASE + int'(CTL_EN);
    localparam int F_PD  = FBASE + int'(CTL_PEND);
    localparam int F_SC  = FBASE + int'(CTL_SCLK);

    logic [NUM_PINS-1:0] oe_q, ie_q, dout_q, mask_q;
    logic [REG_W-1:0]    type_lo_q, type_up_q;
    logic                port_en_q, port_pend_q, sclk_sel_q;
    logic [NUM_PINS-1:0] sync_cur, sync_prev, pin_ev, pin_pend, pend_clr;
    logic                any_unmasked;
    logic                wr_oe, wr_ie, wr_dat, wr_tlo, wr_tup, wr_msk, wr_pnd, wr_ctl;
    logic                rd_go;
    logic [REG_W-1:0]    rd_mux, ctrl_word;

    // Write strobes per register
    always_comb begin
        wr_oe  = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_OUTEN));
        wr_ie  = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_INEN));
        wr_dat = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
        wr_tup = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_TYPE_UP));
        wr_tlo = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_TYPE_LO));
        wr_msk = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_MASK));
        wr_pnd = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_PEND));
        wr_ctl = bus_en && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        rd_go  = bus_en && !bus_wr;
    end

    // Pad direction, mask and trigger configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q      <= '0;
            ie_q      <= '0;
            mask_q    <= '0;
            type_lo_q <= '0;
            type_up_q <= '0;
        end else begin
            if (wr_oe)  oe_q      <= bus_wdata[NUM_PINS-1:0];
            if (wr_ie)  ie_q      <= bus_wdata[NUM_PINS-1:0];
            if (wr_msk) mask_q    <= bus_wdata[NUM_PINS-1:0];
            if (wr_tlo) type_lo_q <= bus_wdata;
            if (wr_tup) type_up_q <= bus_wdata;
        end
    end

    // Output data: only pins with output enabled take the written value
    always_ff @(posedge clk) begin
        if (!rst_n)      dout_q <= '0;
        else if (wr_dat) dout_q <= (dout_q & ~oe_q) | (bus_wdata[NUM_PINS-1:0] & oe_q);
    end

    gib_pin_sync #(.NPINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .cur    (sync_cur),
        .prev   (sync_prev)
    );

    gib_event_detect #(.NPINS(NUM_PINS)) u_detect (
        .cur     (sync_cur),
        .prev    (sync_prev),
        .type_lo (type_lo_q),
        .type_up (type_up_q),
        .ev      (pin_ev)
    );

    // Clear vector from a pending-register write
    always_comb pend_clr = wr_pnd ? bus_wdata[NUM_PINS-1:0] : '0;

    gib_pend_reg #(.NPINS(NUM_PINS)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (pin_ev),
        .clr   (pend_clr),
        .pend  (pin_pend)
    );

    // Any pin both pending and allowed
    always_comb any_unmasked = |(pin_pend & mask_q);

    // Port control field: enable, sticky port pending, sample-clock select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en_q   <= 1'b0;
            port_pend_q <= 1'b0;
            sclk_sel_q  <= 1'b0;
        end else begin
            if (wr_ctl) begin
                port_en_q  <= bus_wdata[F_EN];
                sclk_sel_q <= bus_wdata[F_SC];
            end
            port_pend_q <= (port_pend_q & ~(wr_ctl & bus_wdata[F_PD])) | any_unmasked;
        end
    end

    // Assemble the control word with only this port's field populated
    always_comb begin
        ctrl_word       = '0;
        ctrl_word[F_EN] = port_en_q;
        ctrl_word[F_PD] = port_pend_q;
        ctrl_word[F_SC] = sclk_sel_q;
    end

    // Read multiplexer
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFS_OUTEN):   rd_mux = REG_W'(oe_q);
            ADDR_W'(OFS_INEN):    rd_mux = REG_W'(ie_q);
            ADDR_W'(OFS_DATA):    rd_mux = REG_W'(sync_cur & ie_q);
            ADDR_W'(OFS_TYPE_UP): rd_mux = type_up_q;
            ADDR_W'(OFS_TYPE_LO): rd_mux = type_lo_q;
            ADDR_W'(OFS_MASK):    rd_mux = REG_W'(mask_q);
            ADDR_W'(OFS_PEND):    rd_mux = REG_W'(pin_pend);
            ADDR_W'(OFS_CTRL):    rd_mux = ctrl_word;
            default:              rd_mux = '0;
        endcase
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_go) bus_rdata <= rd_mux;
    end

    // Pad and interrupt outputs
    always_comb begin
        pin_out = dout_q;
        pin_oe  = oe_q;
        pin_ie  = ie_q;
        irq     = port_en_q & any_unmasked;
    end

    // R2: a pin whose output was disabled keeps its output value
    assert_out_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0));

    // R10: an unmasked pending pin always leaves the port-pending flag set
    assert_port_pend_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_unmasked |=> port_pend_q);

endmodule

// File: tb/gpio_irq_bank_tb_top.sv
// Bench: scoreboard style. Read tasks push the expected word into a queue,
// and a monitor pops and compares it when the registered read data returns.
module gpio_irq_bank_tb_top;

    localparam int NP = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_ie;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic rd_fire = 1'b0;
    bit   done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    gpio_irq_bank #(.NUM_PINS(NP), .ADDR_W(AW), .PORT_IDX(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_ie(pin_ie),
        .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare returned read data against the queue head
    always @(posedge clk) begin
        if (rd_fire) begin
            #3;
            if (exp_q.size() == 0) begin
                check(bus_rdata, 32'hDEAD_BEEF, "scoreboard-empty");
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // All tasks start and end at a falling edge
    task automatic wr(input int a, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string req);
        exp_q.push_back(e); tag_q.push_back(req);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a); rd_fire = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_en = 1'b0; rd_fire = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(32'(irq), 32'h0, "R1 irq");
        check(32'(pin_oe), 32'h0, "R1 pin_oe");
        check(32'(pin_out), 32'h0, "R1 pin_out");
        rd('h00, 32'h0, "R1 outen");
        rd('h18, 32'h0, "R1 pend");
        rd('h10, 32'h0, "R1 type_lo");
        rd('h1C, 32'h0, "R1 ctrl");

        // R12 / R2: enables and data output
        wr('h00, 32'h0000_00FF);
        wr('h04, 32'hFFFF_FFFF);
        rd('h00, 32'h0000_00FF, "R12 outen");
        rd('h04, 32'hFFFF_FFFF, "R12 inen");
        check(32'(pin_oe), 32'h0000_00FF, "R2 pin_oe");
        check(32'(pin_ie), 32'hFFFF_FFFF, "R2 pin_ie");
        wr('h08, 32'hFFFF_FFFF);
        check(32'(pin_out), 32'h0000_00FF, "R2 masked data write");
        wr('h08, 32'h0000_0F0F);
        check(32'(pin_out), 32'h0000_000F, "R2 second data write");

        // R3: input path gated by input enable
        pin_in = 32'hA5A5_0003;
        settle();
        rd('h08, 32'hA5A5_0003, "R3 data read");
        wr('h04, 32'h0000_FFFF);
        rd('h08, 32'h0000_0003, "R3 input enable gate");
        wr('h04, 32'hFFFF_FFFF);
        pin_in = '0;
        settle();
        // R7: clear everything captured by the default high-level codes
        wr('h18, 32'hFFFF_FFFF);
        rd('h18, 32'h0, "R7 clear all");

        // R4 / R5: pin0 rise, pin1 fall (lo word), pin17 rise (upper word)
        wr('h10, 32'h0000_000E);
        wr('h0C, 32'h0000_0008);
        rd('h10, 32'h0000_000E, "R12 type_lo");
        rd('h0C, 32'h0000_0008, "R12 type_up");
        pin_in = 32'h0002_0003;
        settle();
        rd('h18, 32'h0002_0001, "R4 rising edges R5 layout");
        wr('h18, 32'h0002_0001);
        rd('h18, 32'h0, "R4 edge not re-armed");
        pin_in = '0;
        settle();
        rd('h18, 32'h0000_0002, "R4 falling edge");
        wr('h18, 32'h0000_0000);
        rd('h18, 32'h0000_0002, "R7 write zero keeps");
        wr('h18, 32'h0000_0002);

        // R6: pin2 low level, pin3 high level
        wr('h10, 32'h0000_001E);
        settle();
        rd('h18, 32'h0000_0004, "R6 low level pending");
        wr('h18, 32'h0000_0004);
        rd('h18, 32'h0000_0004, "R6 clear while low holds");
        pin_in = 32'h0000_0004;
        settle();
        wr('h18, 32'h0000_0004);
        rd('h18, 32'h0, "R6 clear after low released");
        pin_in = 32'h0000_000C;
        settle();
        wr('h18, 32'h0000_0008);
        rd('h18, 32'h0000_0008, "R6 clear while high holds");
        pin_in = 32'h0000_0004;
        settle();
        wr('h18, 32'h0000_0008);
        rd('h18, 32'h0, "R6 clear after high released");

        // R8: clear coincides with a new rising edge on pin0
        pin_in = 32'h0000_0005;
        settle();
        rd('h18, 32'h0000_0001, "R8 setup pend");
        pin_in = 32'h0000_0004;
        settle();
        rd('h18, 32'h0000_0001, "R4 opposite edge ignored");
        pin_in = 32'h0000_0005;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr('h18, 32'h0000_0001);
        rd('h18, 32'h0000_0001, "R8 event beats clear");

        // R9: masking and port enable
        check(32'(irq), 32'h0, "R9 masked disabled");
        wr('h14, 32'h0000_0001);
        check(32'(irq), 32'h0, "R9 port disabled");
        wr('h1C, 32'h0000_0001);
        check(32'(irq), 32'h1, "R9 enabled unmasked");
        wr('h14, 32'h0);
        check(32'(irq), 32'h0, "R9 masked");
        rd('h18, 32'h0000_0001, "R9 pending while masked");
        wr('h14, 32'h0000_0001);
        check(32'(irq), 32'h1, "R9 unmasked again");
        rd('h14, 32'h0000_0001, "R12 mask");

        // R10: port control field
        rd('h1C, 32'h0000_0003, "R10 port pending set");
        wr('h1C, 32'hFFFF_FFE7);
        rd('h1C, 32'h0000_0007, "R10 clear loses to live condition");
        wr('h18, 32'h0000_0001);
        check(32'(irq), 32'h0, "R9 cleared pin drops irq");
        rd('h1C, 32'h0000_0007, "R10 port pending sticky");
        wr('h1C, 32'h0000_0007);
        rd('h1C, 32'h0000_0005, "R10 port pending cleared");
        wr('h1C, 32'h0000_0004);
        rd('h1C, 32'h0000_0004, "R10 select readback");

        // R11: unmapped addresses
        rd('h20, 32'h0, "R11 unmapped read");
        wr('h24, 32'hFFFF_FFFF);
        rd('h00, 32'h0000_00FF, "R11 unmapped write ignored");
        check(32'(pin_out), 32'h0000_000F, "R11 pin_out unchanged");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule